// File: doc/BRIEF.md
# MSI Interrupt Remapping Unit

This unit sits on the path of message-signalled interrupts and handles one 32-bit MSI write (address and data) at a time, together with the 16-bit requester ID of the device that issued it. For each message it reads that device's 64-bit control word from a device-table read port. From that word it decides whether the message passes unchanged, is rewritten from one 32-bit remap entry fetched through a memory read port, or is refused.

The message type in MSI data bits 10:8 chooses the path. Fixed and arbitrated interrupts are governed by a two-bit interrupt-control field, which can pass, remap or abort them. Non-vectored types never touch the remap table and pass only when their own enable bit in the control word is set. Each request ends in a one-cycle done pulse carrying a status code and the outgoing address and data.

Top module: `msi_remap_unit`

## Requirements
- R1: When control-word bit 0 (remap valid) is 0, the message leaves unchanged with status OK (00) and no memory read is issued.
- R2: The remap entry is read at byte address ctl[63:32] + 4 * idx, where idx is MSI data bits IDX_W-1:0.
- R3: With N = ctl[6:3], an index of 2^N or more is aborted (status 01) without a memory read; when N >= IDX_W every index is in range.
- R4: Interrupt control ctl[2:1] for fixed and arbitrated messages: 01 passes the message unchanged with no read, 00 and 11 abort with no read, 10 remaps through the entry.
- R5: A fetched entry whose bit 0 is 0 gives status 01 (abort), and every abort drives zero address and data.
- R6: A remapped address is 0xFEE00000 with entry bits 15:8 at address bits 19:12, entry bit 5 at address bit 3 and entry bit 6 at address bit 2.
- R7: Remapped data holds entry bits 23:16 in data bits 7:0 and entry bits 4:2 in data bits 10:8, all other bits 0.
- R8: NMI, INIT, ExtINT, LINT0 and LINT1 skip the table and pass unchanged when ctl bit 7, 8, 9, 10 or 11 respectively is set; otherwise they abort.
- R9: Type 010 (SMI) and the unused type codes 011 and 110 always abort.
- R10: A memory read returned with its error flag gives status 10 (hardware error) with zero address and data.
- R11: req_ready is high only while idle; each accepted request yields exactly one done pulse, one cycle long.
- R12: Type decode: data[10:8] 000 fixed, 001 arbitrated, 100 NMI, 101 INIT, 111 ExtINT; a lint_sel of 01 (LINT0) or 10 (LINT1) overrides it, and 11 aborts.
- R13: The device table is read at the requester ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and accepting |
| req_addr | input | 32 | Incoming MSI address |
| req_data | input | 32 | Incoming MSI data |
| req_rid | input | 16 | Requester ID |
| lint_sel | input | 2 | 00 normal, 01 LINT0, 10 LINT1, 11 invalid |
| dt_rd_en | output | 1 | Device-table read strobe |
| dt_rd_idx | output | 16 | Device-table index |
| dt_rd_word | input | 64 | Control word, valid the cycle after the strobe |
| mem_rd_en | output | 1 | Entry read request, held until answered |
| mem_rd_addr | output | 32 | Entry byte address |
| mem_rd_valid | input | 1 | Entry read answer, one cycle |
| mem_rd_data | input | 32 | Entry word |
| mem_rd_err | input | 1 | Entry read failed |
| done | output | 1 | Result pulse |
| status | output | 2 | 00 OK, 01 target abort, 10 hardware error |
| out_addr | output | 32 | Outgoing MSI address |
| out_data | output | 32 | Outgoing MSI data |

## Verification
The assertions assume that the device table answers exactly one cycle after its strobe, and that mem_rd_valid is a single-cycle pulse raised only while mem_rd_en is held. The bench's table and memory responders are built to respect this contract. The memory responder waits a random number of cycles before answering and never answers unasked, so the hardware-error and read-start checks see only legal traffic. Random control words, entries and message types are biased toward the remap path, so the range, enable and error cases each occur many times.

// File: rtl/msi_remap_pkg.sv
package msi_remap_pkg;
  typedef enum logic [1:0] {ST_OK = 2'b00, ST_ABORT = 2'b01, ST_HWERR = 2'b10} remap_status_e;
  typedef enum logic [2:0] {CL_VECTORED, CL_NMI, CL_INIT, CL_EXTINT, CL_LINT0, CL_LINT1, CL_BLOCKED} msg_class_e;
  typedef enum logic [1:0] {IC_ABORT = 2'b00, IC_PASS = 2'b01, IC_REMAP = 2'b10, IC_RSVD = 2'b11} int_ctl_e;
  typedef enum logic [1:0] {S_IDLE, S_DT, S_EVAL, S_MEM} fsm_state_e;

  localparam int CTL_VALID   = 0;
  localparam int CTL_IC_LO   = 1;
  localparam int CTL_SIZE_LO = 3;
  localparam int CTL_SIZE_W  = 4;
  localparam int CTL_NMI     = 7;
  localparam int CTL_INIT    = 8;
  localparam int CTL_EXTINT  = 9;
  localparam int CTL_LINT0   = 10;
  localparam int CTL_LINT1   = 11;
  localparam int CTL_ROOT_LO = 32;
  localparam int TYPE_LO     = 8;
  localparam logic [11:0] LAPIC_TOP = 12'hFEE;
endpackage

// File: rtl/msi_class_decode.sv
module msi_class_decode
  import msi_remap_pkg::*;
(
  input  logic [2:0] msg_type,
  input  logic [1:0] lint_sel,
  output msg_class_e cls
);
  always_comb begin
    cls = CL_BLOCKED;
    unique case (lint_sel)
      2'b01: cls = CL_LINT0;
      2'b10: cls = CL_LINT1;
      2'b11: cls = CL_BLOCKED;
      default: begin
        unique case (msg_type)
          3'b000, 3'b001: cls = CL_VECTORED;
          3'b100:         cls = CL_NMI;
          3'b101:         cls = CL_INIT;
          3'b111:         cls = CL_EXTINT;
          default:        cls = CL_BLOCKED;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/msi_index_check.sv
module msi_index_check #(
  parameter int IDX_W  = 8,
  parameter int SIZE_W = 4
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [SIZE_W-1:0] size_n,
  output logic              in_range,
  output logic [IDX_W+1:0]  byte_off
);
  localparam logic [SIZE_W-1:0] FULL_N = SIZE_W'(IDX_W);

  always_comb begin
    byte_off = {idx, 2'b00};
    if (size_n >= FULL_N) in_range = 1'b1;
    else                  in_range = ((idx >> size_n) == '0);
  end

  always_comb begin
    if (size_n == '0) assert (in_range == (idx == '0)) else $error("assert_size_zero_R3");
  end
endmodule

// File: rtl/msi_entry_build.sv
module msi_entry_build
  import msi_remap_pkg::*;
(
  input  logic [31:0] entry,
  output logic        enabled,
  output logic [31:0] new_addr,
  output logic [31:0] new_data
);
  logic unused_entry_bits;
  assign unused_entry_bits = ^{entry[31:24], entry[7], entry[1]};

  always_comb begin
    enabled  = entry[0];
    new_addr = {LAPIC_TOP, entry[15:8], 8'h00, entry[5], entry[6], 2'b00};
    new_data = {21'h0, entry[4:2], entry[23:16]};
  end
endmodule

// File: rtl/msi_remap_unit.sv
module msi_remap_unit
  import msi_remap_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_data,
  input  logic [15:0]       req_rid,
  input  logic [1:0]        lint_sel,
  output logic              dt_rd_en,
  output logic [15:0]       dt_rd_idx,
  input  logic [63:0]       dt_rd_word,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  input  logic              mem_rd_err,
  output logic              done,
  output logic [1:0]        status,
  output logic [31:0]       out_addr,
  output logic [31:0]       out_data
);
  localparam int OFF_W = IDX_W + 2;

  fsm_state_e    state_q, state_d;
  logic [31:0]   raddr_q, rdata_q;
  logic [15:0]   rid_q;
  logic [1:0]    lint_q;
  logic [ADDR_W-1:0] maddr_q, maddr_d;
  logic          done_q;
  remap_status_e st_q, st_d;
  logic [31:0]   oaddr_q, odata_q, oaddr_d, odata_d;
  logic          load_req, fin, go_mem;

  msg_class_e        cls;
  logic              in_range;
  logic [OFF_W-1:0]  byte_off;
  logic              ent_en;
  logic [31:0]       ent_addr, ent_data;
  int_ctl_e          ic;
  logic unused_ctl_bits;
  assign unused_ctl_bits = ^dt_rd_word[31:12];

  msi_class_decode u_decode (
    .msg_type (rdata_q[TYPE_LO+2:TYPE_LO]),
    .lint_sel (lint_q),
    .cls      (cls)
  );

  msi_index_check #(.IDX_W(IDX_W), .SIZE_W(CTL_SIZE_W)) u_range (
    .idx      (rdata_q[IDX_W-1:0]),
    .size_n   (dt_rd_word[CTL_SIZE_LO+CTL_SIZE_W-1:CTL_SIZE_LO]),
    .in_range (in_range),
    .byte_off (byte_off)
  );

  msi_entry_build u_build (
    .entry    (mem_rd_data),
    .enabled  (ent_en),
    .new_addr (ent_addr),
    .new_data (ent_data)
  );

  assign ic = int_ctl_e'(dt_rd_word[CTL_IC_LO+1:CTL_IC_LO]);

  // next-state and result selection
  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    go_mem   = 1'b0;
    st_d     = ST_OK;
    oaddr_d  = raddr_q;
    odata_d  = rdata_q;
    maddr_d  = dt_rd_word[CTL_ROOT_LO+ADDR_W-1:CTL_ROOT_LO] + ADDR_W'(byte_off);
    load_req = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          load_req = 1'b1;
          state_d  = S_DT;
        end
      end
      S_DT: state_d = S_EVAL;
      S_EVAL: begin
        if (!dt_rd_word[CTL_VALID]) begin
          fin = 1'b1;
        end else begin
          unique case (cls)
            CL_VECTORED: begin
              if (ic == IC_PASS)                 fin = 1'b1;
              else if (ic == IC_REMAP && in_range) go_mem = 1'b1;
              else begin fin = 1'b1; st_d = ST_ABORT; end
            end
            CL_NMI:    begin fin = 1'b1; if (!dt_rd_word[CTL_NMI])    st_d = ST_ABORT; end
            CL_INIT:   begin fin = 1'b1; if (!dt_rd_word[CTL_INIT])   st_d = ST_ABORT; end
            CL_EXTINT: begin fin = 1'b1; if (!dt_rd_word[CTL_EXTINT]) st_d = ST_ABORT; end
            CL_LINT0:  begin fin = 1'b1; if (!dt_rd_word[CTL_LINT0])  st_d = ST_ABORT; end
            CL_LINT1:  begin fin = 1'b1; if (!dt_rd_word[CTL_LINT1])  st_d = ST_ABORT; end
            default:   begin fin = 1'b1; st_d = ST_ABORT; end
          endcase
        end
        state_d = go_mem ? S_MEM : S_IDLE;
      end
      S_MEM: begin
        if (mem_rd_valid) begin
          fin     = 1'b1;
          state_d = S_IDLE;
          if (mem_rd_err)   st_d = ST_HWERR;
          else if (!ent_en) st_d = ST_ABORT;
          else begin
            oaddr_d = ent_addr;
            odata_d = ent_data;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (st_d != ST_OK) begin
      oaddr_d = '0;
      odata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      raddr_q <= '0;
      rdata_q <= '0;
      rid_q   <= '0;
      lint_q  <= '0;
      maddr_q <= '0;
      done_q  <= 1'b0;
      st_q    <= ST_OK;
      oaddr_q <= '0;
      odata_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (load_req) begin
        raddr_q <= req_addr;
        rdata_q <= req_data;
        rid_q   <= req_rid;
        lint_q  <= lint_sel;
      end
      if (go_mem) maddr_q <= maddr_d;
      if (fin) begin
        st_q    <= st_d;
        oaddr_q <= oaddr_d;
        odata_q <= odata_d;
      end
    end
  end

  assign req_ready   = (state_q == S_IDLE);
  assign dt_rd_en    = (state_q == S_DT);
  assign dt_rd_idx   = rid_q;
  assign mem_rd_en   = (state_q == S_MEM);
  assign mem_rd_addr = maddr_q;
  assign done        = done_q;
  assign status      = st_q;
  assign out_addr    = oaddr_q;
  assign out_data    = odata_q;

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_hwerr_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_HWERR) |-> $past(mem_rd_valid && mem_rd_err));
  assert_abort_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != ST_OK) |-> (out_addr == 32'h0 && out_data == 32'h0));
  assert_read_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_en) |-> $past(dt_rd_word[CTL_VALID]));
  assert_remap_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_OK && $past(mem_rd_en)) |-> out_addr[31:20] == LAPIC_TOP);
endmodule

// File: tb/tb_msi_remap_unit.sv
module tb_msi_remap_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready;
  logic [31:0] req_addr, req_data;
  logic [15:0] req_rid;
  logic [1:0]  lint_sel;
  logic dt_rd_en;
  logic [15:0] dt_rd_idx;
  logic [63:0] dt_rd_word;
  logic mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic mem_rd_valid, mem_rd_err;
  logic [31:0] mem_rd_data;
  logic done;
  logic [1:0] status;
  logic [31:0] out_addr, out_data;

  int n_checks = 0, n_fail = 0;
  int rd_count = 0;
  int mem_delay = 0, mem_cnt = 0;
  logic [31:0] last_rd_addr;
  logic [15:0] last_dt_idx;
  logic [63:0] ctl_cur;
  logic [31:0] ent_cur;
  logic        err_cur;

  always #10 clk = ~clk;

  msi_remap_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_rid(req_rid), .lint_sel(lint_sel),
    .dt_rd_en(dt_rd_en), .dt_rd_idx(dt_rd_idx), .dt_rd_word(dt_rd_word),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err), .done(done),
    .status(status), .out_addr(out_addr), .out_data(out_data));

  // device table: answers one cycle after strobe
  always @(posedge clk) begin
    if (dt_rd_en) begin
      dt_rd_word  <= ctl_cur;
      last_dt_idx <= dt_rd_idx;
    end else begin
      dt_rd_word  <= 64'h0;
    end
  end

  // memory: answers after mem_delay cycles, one-cycle valid
  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (!mem_rd_en) mem_cnt <= 0;
    else if (!mem_rd_valid) begin
      if (mem_cnt >= mem_delay) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= ent_cur;
        mem_rd_err   <= err_cur;
        last_rd_addr <= mem_rd_addr;
        rd_count     <= rd_count + 1;
        mem_cnt      <= 0;
      end else mem_cnt <= mem_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, input logic [31:0] d,
      input logic [1:0] lint, input logic [63:0] ctl, input logic [31:0] ent,
      input logic err, output logic [1:0] st, output logic [31:0] oa,
      output logic [31:0] od, output bit rd, output logic [31:0] raddr,
      output string tag);
    int bitpos;
    bit vect, blocked;
    logic [3:0] n;
    st = 2'b00; oa = a; od = d; rd = 0; tag = "R1";
    raddr = ctl[63:32] + {22'h0, d[7:0], 2'b00};
    if (!ctl[0]) return;
    vect = 0; blocked = 0; bitpos = 0;
    if (lint == 2'b01) begin bitpos = 10; tag = "R12"; end
    else if (lint == 2'b10) begin bitpos = 11; tag = "R12"; end
    else if (lint == 2'b11) begin blocked = 1; tag = "R12"; end
    else begin
      case (d[10:8])
        3'b000, 3'b001: vect = 1;
        3'b100: begin bitpos = 7; tag = "R8"; end
        3'b101: begin bitpos = 8; tag = "R8"; end
        3'b111: begin bitpos = 9; tag = "R8"; end
        default: begin blocked = 1; tag = "R9"; end
      endcase
    end
    if (blocked) st = 2'b01;
    else if (!vect) begin
      if (!ctl[bitpos]) st = 2'b01;
    end else begin
      tag = "R4";
      n = ctl[6:3];
      case (ctl[2:1])
        2'b01: ;
        2'b10: begin
          if (n < 8 && (d[7:0] >> n) != 0) begin st = 2'b01; tag = "R3"; end
          else begin
            rd = 1;
            if (err) begin st = 2'b10; tag = "R10"; end
            else if (!ent[0]) begin st = 2'b01; tag = "R5"; end
            else begin
              tag = "R6";
              oa = 32'hFEE00000 | ({24'h0, ent[15:8]} << 12) | ({31'h0, ent[5]} << 3) | ({31'h0, ent[6]} << 2);
              od = {24'h0, ent[23:16]} | ({29'h0, ent[4:2]} << 8);
            end
          end
        end
        default: st = 2'b01;
      endcase
    end
    if (st != 2'b00) begin oa = 0; od = 0; end
  endfunction

  task automatic run_txn(input logic [31:0] a, input logic [31:0] d, input logic [15:0] rid,
                         input logic [1:0] lint, input logic [63:0] ctl,
                         input logic [31:0] ent, input logic err, input int dly);
    logic [1:0] est; logic [31:0] eoa, eod, erad; bit erd; string tag;
    int rd0, waited;
    model(a, d, lint, ctl, ent, err, est, eoa, eod, erd, erad, tag);
    @(negedge clk);
    ctl_cur = ctl; ent_cur = ent; err_cur = err; mem_delay = dly;
    req_addr = a; req_data = d; req_rid = rid; lint_sel = lint; req_valid = 1'b1;
    rd0 = rd_count;
    chk(req_ready == 1'b1, "R11", "ready while idle", {63'h0, req_ready}, 64'h1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11", "ready while busy", {63'h0, req_ready}, 64'h0);
    waited = 0;
    while (!done && waited < 60) begin
      @(negedge clk);
      waited++;
    end
    if (!done) begin
      chk(1'b0, "R11", "watchdog, no done", 64'h0, 64'h1);
      return;
    end
    chk(last_dt_idx == rid, "R13", "table index", {48'h0, last_dt_idx}, {48'h0, rid});
    chk(status == est, tag, "status", {62'h0, status}, {62'h0, est});
    chk(out_addr == eoa, (tag == "R6") ? "R6" : tag, "address", {32'h0, out_addr}, {32'h0, eoa});
    chk(out_data == eod, (tag == "R6") ? "R7" : tag, "data", {32'h0, out_data}, {32'h0, eod});
    chk((rd_count - rd0) == int'(erd), erd ? "R2" : tag, "read count",
        64'(rd_count - rd0), 64'(erd));
    if (erd) chk(last_rd_addr == erad, "R2", "entry address", {32'h0, last_rd_addr}, {32'h0, erad});
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R11", "single done pulse",
        {62'h0, done, req_ready}, 64'h1);
  endtask

  function automatic logic [31:0] mk_data(input logic [2:0] ty, input logic [7:0] idx,
                                          input logic [31:0] junk);
    return {junk[31:11], ty, idx};
  endfunction

  function automatic logic [63:0] mk_ctl(input logic [31:0] root, input logic [4:0] pass,
      input logic [3:0] n, input logic [1:0] ic, input logic valid);
    return {root, 20'h0, pass, n, ic, valid};
  endfunction

  initial begin
    logic [63:0] c;
    logic [31:0] e;
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = 0; req_data = 0; req_rid = 0; lint_sel = 0;
    ctl_cur = 0; ent_cur = 0; err_cur = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && dt_rd_en == 1'b0 && mem_rd_en == 1'b0,
        "R11", "reset state", {60'h0, req_ready, done, dt_rd_en, mem_rd_en}, 64'h8);
    rst_n = 1'b1;
    e = 32'h00AB_5A7D;
    // R1: remap disabled, even on remap control
    run_txn(32'hFEE0_1000, mk_data(3'b000, 8'h05, 32'h0), 16'h0012, 2'b00,
            mk_ctl(32'h1000_0000, 5'h0, 4'd8, 2'b10, 1'b0), e, 1'b0, 0);
    // R4: pass and abort controls
    run_txn(32'hFEE0_2000, mk_data(3'b001, 8'h01, 32'h0), 16'h0034, 2'b00,
            mk_ctl(32'h1000_0000, 5'h0, 4'd8, 2'b01, 1'b1), e, 1'b0, 0);
    run_txn(32'hFEE0_2000, mk_data(3'b000, 8'h01, 32'h0), 16'h0034, 2'b00,
            mk_ctl(32'h1000_0000, 5'h0, 4'd8, 2'b00, 1'b1), e, 1'b0, 0);
    run_txn(32'hFEE0_2000, mk_data(3'b000, 8'h01, 32'h0), 16'h0034, 2'b00,
            mk_ctl(32'h1000_0000, 5'h0, 4'd8, 2'b11, 1'b1), e, 1'b0, 0);
    // R3: last index in range, first out of range, N at index width
    run_txn(32'hFEE0_0000, mk_data(3'b000, 8'h0F, 32'h0), 16'h0100, 2'b00,
            mk_ctl(32'h2000_0040, 5'h0, 4'd4, 2'b10, 1'b1), e, 1'b0, 2);
    run_txn(32'hFEE0_0000, mk_data(3'b000, 8'h10, 32'h0), 16'h0100, 2'b00,
            mk_ctl(32'h2000_0040, 5'h0, 4'd4, 2'b10, 1'b1), e, 1'b0, 2);
    run_txn(32'hFEE0_0000, mk_data(3'b000, 8'hFF, 32'h0), 16'h0100, 2'b00,
            mk_ctl(32'h2000_0040, 5'h0, 4'd8, 2'b10, 1'b1), e, 1'b0, 1);
    run_txn(32'hFEE0_0000, mk_data(3'b000, 8'h01, 32'h0), 16'h0100, 2'b00,
            mk_ctl(32'h2000_0040, 5'h0, 4'd0, 2'b10, 1'b1), e, 1'b0, 0);
    // R5 and R10
    run_txn(32'hFEE0_0000, mk_data(3'b000, 8'h02, 32'h0), 16'h0200, 2'b00,
            mk_ctl(32'h3000_0000, 5'h0, 4'd8, 2'b10, 1'b1), 32'h00AB_5A7C, 1'b0, 0);
    run_txn(32'hFEE0_0000, mk_data(3'b000, 8'h02, 32'h0), 16'h0200, 2'b00,
            mk_ctl(32'h3000_0000, 5'h0, 4'd8, 2'b10, 1'b1), e, 1'b1, 3);
    // R9 SMI, R8 NMI off and on, R12 LINT0/LINT1
    run_txn(32'hFEE0_0000, mk_data(3'b010, 8'h00, 32'h0), 16'h0300, 2'b00,
            mk_ctl(32'h0, 5'h1F, 4'd8, 2'b01, 1'b1), e, 1'b0, 0);
    run_txn(32'hFEE0_0000, mk_data(3'b100, 8'h00, 32'h0), 16'h0300, 2'b00,
            mk_ctl(32'h0, 5'h00, 4'd8, 2'b01, 1'b1), e, 1'b0, 0);
    run_txn(32'hFEE0_0000, mk_data(3'b100, 8'h00, 32'h0), 16'h0300, 2'b00,
            mk_ctl(32'h0, 5'h01, 4'd8, 2'b00, 1'b1), e, 1'b0, 0);
    run_txn(32'hFEE0_0000, mk_data(3'b000, 8'h00, 32'h0), 16'h0300, 2'b01,
            mk_ctl(32'h0, 5'h08, 4'd8, 2'b00, 1'b1), e, 1'b0, 0);
    run_txn(32'hFEE0_0000, mk_data(3'b000, 8'h00, 32'h0), 16'h0300, 2'b10,
            mk_ctl(32'h0, 5'h08, 4'd8, 2'b01, 1'b1), e, 1'b0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] ty; logic [1:0] ic, ln; logic [3:0] n;
      ty = ($urandom % 3 != 0) ? 3'($urandom % 2) : 3'($urandom);
      ic = ($urandom % 5 < 3) ? 2'b10 : 2'($urandom);
      n  = 4'($urandom % 10);
      ln = ($urandom % 6 == 0) ? 2'($urandom) : 2'b00;
      c  = mk_ctl($urandom, 5'($urandom), n, ic, ($urandom % 7 != 0));
      e  = $urandom;
      if ($urandom % 10 != 0) e[0] = 1'b1;
      run_txn($urandom, mk_data(ty, 8'($urandom), $urandom), 16'($urandom), ln, c, e,
              ($urandom % 10 == 0), int'($urandom % 4));
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule